// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, A and B, each of configurable width (eight bits by default). Each side has its own storage register, loaded from that side's bus whenever that side's capture strobe shows a rising edge. Exactly one direction can be driven at a time, or neither. The driving side is set by an active-low enable and a direction input. For each direction, a select input chooses whether the driven bus carries the live value of the opposite bus or the opposite side's stored register.

Bidirectional pads are represented as an input vector, an output vector and an output-enable per side, so the block maps onto plain FPGA or ASIC logic. The capture strobes are ordinary signals sampled on the block clock `clk`. A register loads when its strobe is seen high after having been seen low. Both registers keep loading while the outputs are isolated, so data can be collected from a bus that the block is not driving.

Top module: `xcv_bus_transceiver`

## Requirements
- R1: A synchronous active-low reset clears both storage registers to zero. A stored-mode readout taken after reset shows all zeros.
- R2: The A register loads `a_in` on any `clk` edge where `a_cap` is 1 and was 0 at the previous `clk` edge. The new value is visible at the outputs from that edge onward.
- R3: The B register loads `b_in` on any `clk` edge where `b_cap` is 1 and was 0 at the previous `clk` edge. The new value is visible at the outputs from that edge onward.
- R4: Loading depends only on the capture strobe. `en_n`, `a_to_b`, `sel_a_stored` and `sel_b_stored` have no effect on whether or what a register stores.
- R5: With `en_n` = 1, both `a_oe` and `b_oe` are 0 and both output vectors are 0.
- R6: With `en_n` = 0, `a_to_b` = 1 gives `b_oe` = 1 and `a_oe` = 0. `a_to_b` = 0 gives `a_oe` = 1 and `b_oe` = 0. `a_oe` and `b_oe` are never both 1.
- R7: While `b_oe` = 1, `b_out` equals `a_in` in the same cycle when `sel_a_stored` = 0, and equals the A register when `sel_a_stored` = 1.
- R8: While `a_oe` = 1, `a_out` equals `b_in` in the same cycle when `sel_b_stored` = 0, and equals the B register when `sel_b_stored` = 1.
- R9: A strobe held at 1 for several cycles loads its register only once, at the first edge. Reset leaves each strobe's history as "was high", so a strobe that is already high when reset is released does not load.
- R10: When a register loads while its direction is driven in stored mode, the driven output shows the new value from the loading edge onward, with no extra cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; strobes are sampled and registers load on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| a_cap | input | 1 | A-side capture strobe; a rising edge loads the A register |
| b_cap | input | 1 | B-side capture strobe; a rising edge loads the B register |
| en_n | input | 1 | Active-low output enable; 1 isolates both sides |
| a_to_b | input | 1 | Direction: 1 drives B, 0 drives A |
| sel_a_stored | input | 1 | A-to-B source: 0 live A bus, 1 A register |
| sel_b_stored | input | 1 | B-to-A source: 0 live B bus, 1 B register |
| a_in | input | W | A bus as seen at the pads |
| a_out | output | W | Value driven onto the A bus |
| a_oe | output | 1 | A pad output enable |
| b_in | input | W | B bus as seen at the pads |
| b_out | output | W | Value driven onto the B bus |
| b_oe | output | 1 | B pad output enable |

## Verification
Register loading and stored-mode output fall in the same cycle when a strobe rises while its register is selected onto the driven bus. Loading into one side also falls in the same cycle as live transfer in the other direction. The bench provokes both cases with random strobes, random controls and random bus data. It also uses directed cases for isolated capture and held strobes. Each cycle, a bench model of both registers predicts the driven value and the enables, and the outputs are compared against that prediction both before and after each loading edge.

// File: rtl/xcv_pkg.sv
// Shared definitions for the registered bus transceiver.
package xcv_pkg;
    localparam int unsigned XCV_DEF_W = 8;

    // Source choice for one transfer direction.
    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } xcv_src_e;
endpackage

// File: rtl/xcv_capture.sv
// One side's storage register with rising-edge detection of its strobe.
// Assumes the strobe is synchronous to clk and stays at each level for at least one clk period.
module xcv_capture #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic cap_prev;
    logic load;

    // Rising edge of the strobe as seen on this clk edge.
    assign load = cap && !cap_prev;

    // Strobe history; reset to "was high" so a strobe already high at release does not load.
    always_ff @(posedge clk) begin
        if (!rst_n) cap_prev <= 1'b1;
        else        cap_prev <= cap;
    end

    // Storage register, loaded on each detected strobe edge.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end

    AST_LOAD_TAKES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && !cap_prev) |=> (q == $past(d))); // R2
    AST_HOLD_WITHOUT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap && !cap_prev) |=> $stable(q)); // R9
endmodule

// File: rtl/xcv_route.sv
// Direction decode and source selection for both buses.
// Purely combinational. Assumes the register values come from xcv_capture.
module xcv_route
    import xcv_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         en_n,
    input  logic         a_to_b,
    input  xcv_src_e     src_ab,
    input  xcv_src_e     src_ba,
    input  logic [W-1:0] a_live,
    input  logic [W-1:0] b_live,
    input  logic [W-1:0] a_reg,
    input  logic [W-1:0] b_reg,
    output logic [W-1:0] a_drv,
    output logic         a_en,
    output logic [W-1:0] b_drv,
    output logic         b_en
);
    logic [W-1:0] ab_pick;
    logic [W-1:0] ba_pick;

    // Per-direction source multiplexers.
    always_comb begin
        ab_pick = (src_ab == SRC_STORED) ? a_reg : a_live;
        ba_pick = (src_ba == SRC_STORED) ? b_reg : b_live;
    end

    // Enable decode; an isolated side drives zeros.
    always_comb begin
        b_en  = !en_n && a_to_b;
        a_en  = !en_n && !a_to_b;
        b_drv = b_en ? ab_pick : '0;
        a_drv = a_en ? ba_pick : '0;
    end

    always_comb begin
        AST_ONE_SIDE_ONLY: assert (!(a_en && b_en)); // R6
    end
endmodule

// File: rtl/xcv_bus_transceiver.sv
// Registered bidirectional transceiver between buses A and B.
// Each side has an edge-loaded register. Outputs follow controls and live data combinationally.
// Assumes an external bus model returns the driven value on the driven side's input vector.
module xcv_bus_transceiver
    import xcv_pkg::*;
#(
    parameter int unsigned W = XCV_DEF_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         a_cap,
    input  logic         b_cap,
    input  logic         en_n,
    input  logic         a_to_b,
    input  logic         sel_a_stored,
    input  logic         sel_b_stored,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_oe
);
    logic [W-1:0] a_q;
    logic [W-1:0] b_q;
    xcv_src_e     src_ab;
    xcv_src_e     src_ba;

    assign src_ab = xcv_src_e'(sel_a_stored);
    assign src_ba = xcv_src_e'(sel_b_stored);

    xcv_capture #(.W(W)) u_cap_a (
        .clk(clk), .rst_n(rst_n), .cap(a_cap), .d(a_in), .q(a_q)
    );

    xcv_capture #(.W(W)) u_cap_b (
        .clk(clk), .rst_n(rst_n), .cap(b_cap), .d(b_in), .q(b_q)
    );

    xcv_route #(.W(W)) u_route (
        .en_n(en_n), .a_to_b(a_to_b), .src_ab(src_ab), .src_ba(src_ba),
        .a_live(a_in), .b_live(b_in), .a_reg(a_q), .b_reg(b_q),
        .a_drv(a_out), .a_en(a_oe), .b_drv(b_out), .b_en(b_oe)
    );

    AST_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |-> (!a_oe && !b_oe)); // R5
    AST_DIR_B_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && a_to_b) |-> (b_oe && !a_oe)); // R6
    AST_STORED_TO_B: assert property (@(posedge clk) disable iff (!rst_n)
        (b_oe && sel_a_stored) |-> (b_out == a_q)); // R7
    AST_STORED_TO_A: assert property (@(posedge clk) disable iff (!rst_n)
        (a_oe && sel_b_stored) |-> (a_out == b_q)); // R8
    AST_LIVE_TO_A: assert property (@(posedge clk) disable iff (!rst_n)
        (a_oe && !sel_b_stored) |-> (a_out == b_in)); // R8
endmodule

// File: tb/sim_xcv_bus_transceiver.sv
module sim_xcv_bus_transceiver;
    localparam int W = 8;
    localparam int CYC = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_cap = 1'b0, b_cap = 1'b0, en_n = 1'b1, a_to_b = 1'b0;
    logic sel_a_stored = 1'b0, sel_b_stored = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0, a_ext = '0, b_ext = '0;
    logic [W-1:0] a_out, b_out;
    logic a_oe, b_oe;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Bench model of the two registers and strobe history.
    logic [W-1:0] m_a = '0, m_b = '0;
    logic m_pa = 1'b1, m_pb = 1'b1;

    always #(CYC/2) clk = ~clk;

    xcv_bus_transceiver #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .a_cap(a_cap), .b_cap(b_cap), .en_n(en_n),
        .a_to_b(a_to_b), .sel_a_stored(sel_a_stored), .sel_b_stored(sel_b_stored),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    // Model update (R1, R2, R3, R4, R9).
    always @(posedge clk) begin
        if (!rst_n) begin
            m_a <= '0; m_b <= '0; m_pa <= 1'b1; m_pb <= 1'b1;
        end else begin
            if (a_cap && !m_pa) m_a <= a_in;
            if (b_cap && !m_pb) m_b <= b_in;
            m_pa <= a_cap;
            m_pb <= b_cap;
        end
    end

    function automatic logic exp_aoe(input logic e, input logic d);
        return !e && !d;
    endfunction

    function automatic logic exp_boe(input logic e, input logic d);
        return !e && d;
    endfunction

    // Bus model: the driven side sees its own output, the other side sees the external driver.
    task automatic settle();
        a_in = a_ext; b_in = b_ext;
        #1;
        if (a_oe) a_in = a_out;
        if (b_oe) b_in = b_out;
        #1;
    endtask

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare all outputs to model predictions for the current inputs.
    task automatic check_all();
        logic eb, ea;
        ea = exp_aoe(en_n, a_to_b);
        eb = exp_boe(en_n, a_to_b);
        chk(en_n ? "R5" : "R6", {7'd0, a_oe}, {7'd0, ea});
        chk(en_n ? "R5" : "R6", {7'd0, b_oe}, {7'd0, eb});
        if (eb) chk(sel_a_stored ? "R7/R10" : "R7", b_out, sel_a_stored ? m_a : a_in);
        else    chk("R5", b_out, '0);
        if (ea) chk(sel_b_stored ? "R8/R10" : "R8", a_out, sel_b_stored ? m_b : b_in);
        else    chk("R5", a_out, '0);
    endtask

    task automatic drive(input logic ac, input logic bc, input logic e, input logic d,
                         input logic sa, input logic sb, input logic [W-1:0] ax,
                         input logic [W-1:0] bx);
        @(negedge clk);
        a_cap = ac; b_cap = bc; en_n = e; a_to_b = d;
        sel_a_stored = sa; sel_b_stored = sb; a_ext = ax; b_ext = bx;
        settle();
        check_all();
    endtask

    initial begin
        #(200000 * CYC);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4217));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: stored readout after reset is zero in both directions.
        drive(0, 0, 0, 1, 1, 1, 8'h5A, 8'hC3);
        chk("R1", b_out, '0);
        drive(0, 0, 0, 0, 1, 1, 8'h5A, 8'hC3);
        chk("R1", a_out, '0);
        // R4/R2/R3: capture while isolated, then read back stored.
        drive(1, 1, 1, 0, 0, 0, 8'h96, 8'h3C);
        drive(0, 0, 0, 1, 1, 1, 8'h00, 8'hFF);
        chk("R2", b_out, 8'h96);
        drive(0, 0, 0, 0, 1, 1, 8'h00, 8'hFF);
        chk("R3", a_out, 8'h3C);
        // R9: held strobe loads once only.
        drive(1, 0, 0, 1, 1, 0, 8'h11, 8'h00);
        drive(1, 0, 0, 1, 1, 0, 8'h22, 8'h00);
        drive(1, 0, 0, 1, 1, 0, 8'h33, 8'h00);
        chk("R9", b_out, 8'h11);
        // R10: load while stored mode drives B; new value on next sample.
        drive(0, 0, 0, 1, 1, 0, 8'h44, 8'h00);
        drive(1, 0, 0, 1, 1, 0, 8'hA7, 8'h00);
        drive(1, 0, 0, 1, 1, 0, 8'h00, 8'h00);
        chk("R10", b_out, 8'hA7);
        // Random mix over every control combination (R2..R8, R10).
        for (int i = 0; i < 2000; i++) begin
            drive(1'($urandom), 1'($urandom), 1'($urandom % 4 == 0), 1'($urandom),
                  1'($urandom), 1'($urandom), W'($urandom), W'($urandom));
        end
        // R9: strobe high across reset does not load at release.
        @(negedge clk);
        rst_n = 1'b0; a_cap = 1'b1; a_ext = 8'hEE; settle();
        @(negedge clk);
        rst_n = 1'b1;
        drive(1, 0, 0, 1, 1, 0, 8'hEE, 8'h00);
        drive(1, 0, 0, 1, 1, 0, 8'hEE, 8'h00);
        chk("R9", b_out, 8'h00);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule